// File: doc/BRIEF.md
# Oldest-First Micro-Op Port Dispatcher

This block is the select stage of a unified scheduler. Every cycle it looks at a window of scheduler entries. Each entry carries a valid flag, a ready flag, a wrap-aware age and a 4-bit operation class. The block assigns up to eight ready micro-ops to eight execution ports. A fixed table says which ports can run each operation class, and the table is uneven: some classes have one home port and others may go to two or three. Ports that share a class must therefore be arbitrated against each other. Oldest ready work always gets priority.

Ports are resolved in ascending order. Each port takes the oldest eligible entry that no lower-numbered port has already claimed. A multi-port micro-op therefore lands on its lowest free eligible port and falls back to a higher one when it loses there. A per-port busy input masks a port for the current cycle. A divider sits behind port 0 and is not fully pipelined. An internal spacing counter keeps divide grants apart while other classes continue to use port 0.

The selection is combinational within one cycle. The grant valid flags and entry indices are registered, so they appear on the outputs one cycle after the inputs that caused them.

Top module: `dispatch_select`

## Requirements
- R1: While `rst_ni` is low, and at the first edge after it with an empty window, every bit of `grant_vld_o` is 0.
- R2: Only an entry with both `ent_vld_i` and `ent_rdy_i` set can be granted; any other entry is never granted, regardless of its age.
- R3: Class codes and their eligible ports are fixed:
  - 0 integer ALU: ports {0,1,5,6}
  - 1 shift: {0,6}
  - 2 branch: {0,6}
  - 3 address arithmetic: {1,5}
  - 4 integer multiply: {1}
  - 5 SIMD multiply/shift: {0}
  - 6 fused multiply-add: {0,1}
  - 7 FP multiply: {0}
  - 8 divide: {0}
  - 9 FP add: {1}
  - 10 vector ALU: {1}
  - 11 shuffle: {5}
  - 12 blend: {1,5}
  - 13 load: {2,3}
  - 14 store address: {2,3,7}
  - 15 store data: {4}
  
  A grant is only ever given on an eligible port.
- R4: Among candidates for a port, the oldest wins. Age `a` is older than `b` when bit AGE_W-1 of `(a-b) mod 2^AGE_W` is 1. Equal ages go to the lower entry index. Ages in the window are assumed to span less than half the age range.
- R5: Ports are resolved from 0 to 7. An entry claimed by a lower port is not a candidate for any higher port, so no entry is granted twice in a cycle, and a multi-port entry falls back to its next eligible port.
- R6: When `port_busy_i[p]` is 1, port p grants nothing that cycle. Entries eligible elsewhere may go to their other ports.
- R7: Two divide grants on port 0 are at least DIV_GAP cycles apart (default 4). While the divider is blocked, non-divide classes can still be granted on port 0.
- R8: Grants are registered. Outputs reflect the inputs present at the previous rising edge of `clk_i`, and a port with no grant shows valid 0.
- R9: All eight ports can grant in the same cycle, including two branches at once (ports 0 and 6).
- R10: Memory classes use only ports 2, 3, 4 and 7: loads use 2 and 3, store addresses use 2, 3 and 7, and store data uses 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ent_vld_i | input | N_ENT | Entry holds a micro-op |
| ent_rdy_i | input | N_ENT | Entry operands are ready |
| ent_age_i | input | N_ENT x AGE_W | Wrap-aware sequence number per entry |
| ent_cls_i | input | N_ENT x 4 | Operation class code per entry (R3) |
| port_busy_i | input | 8 | Port cannot accept a micro-op this cycle |
| grant_vld_o | output | 8 | Port has a registered grant |
| grant_idx_o | output | 8 x IDX_W | Entry index granted to each port |

## Verification
Several directed window patterns are applied, and each one separates a different property of the select logic:
- A set of same-class ALU entries in scrambled slot order shows that age, not slot position, decides the winner.
- Entries that are not ready or not valid but carry the oldest ages show the masking.
- A pair of ages straddling the wrap point, together with a pair of equal ages, checks the wrap-aware compare and the index tie-break.
- A busy port, an older address-arithmetic op shadowing an integer multiply, and a fully populated window with eight distinct class mixes check fallback, single-grant and full-width dispatch.
- A series of back-to-back divides mixed with an FP multiply checks the divider spacing and confirms that port 0 stays usable while the divider is blocked.

// File: rtl/dispatch_pkg.sv
`timescale 1ns/1ps
package dispatch_pkg;
  localparam int NPORTS = 8;
  localparam int CLS_W  = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU   = 4'd0,  CLS_SHIFT = 4'd1,  CLS_BRANCH = 4'd2,  CLS_LEA   = 4'd3,
    CLS_IMUL  = 4'd4,  CLS_VMUL  = 4'd5,  CLS_FMA    = 4'd6,  CLS_FMUL  = 4'd7,
    CLS_DIV   = 4'd8,  CLS_FADD  = 4'd9,  CLS_VALU   = 4'd10, CLS_SHUF  = 4'd11,
    CLS_BLEND = 4'd12, CLS_LOAD  = 4'd13, CLS_STA    = 4'd14, CLS_STD   = 4'd15
  } uop_cls_e;

  // bit p set: port p can execute the class
  function automatic logic [NPORTS-1:0] cls_port_mask(logic [CLS_W-1:0] c);
    case (uop_cls_e'(c))
      CLS_ALU:    return 8'b0110_0011;
      CLS_SHIFT,
      CLS_BRANCH: return 8'b0100_0001;
      CLS_LEA,
      CLS_BLEND:  return 8'b0010_0010;
      CLS_IMUL,
      CLS_FADD,
      CLS_VALU:   return 8'b0000_0010;
      CLS_VMUL,
      CLS_FMUL,
      CLS_DIV:    return 8'b0000_0001;
      CLS_FMA:    return 8'b0000_0011;
      CLS_SHUF:   return 8'b0010_0000;
      CLS_LOAD:   return 8'b0000_1100;
      CLS_STA:    return 8'b1000_1100;
      default:    return 8'b0001_0000; // store data
    endcase
  endfunction

  function automatic logic port_ok(logic [CLS_W-1:0] c, int p);
    logic [NPORTS-1:0] m;
    m = cls_port_mask(c);
    return m[p];
  endfunction
endpackage

// File: rtl/disp_age_matrix.sv
`timescale 1ns/1ps
module disp_age_matrix #(
  parameter int N_ENT = 16,
  parameter int AGE_W = 6
) (
  input  logic [N_ENT-1:0][AGE_W-1:0] age_i,
  output logic [N_ENT-1:0][N_ENT-1:0] beats_o   // [i][j]: i has priority over j
);
  always_comb begin
    logic [AGE_W-1:0] diff;
    beats_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      for (int j = 0; j < N_ENT; j++) begin
        diff = age_i[i] - age_i[j];
        if (i != j)
          beats_o[i][j] = diff[AGE_W-1] || ((diff == '0) && (i < j));
      end
    end
  end
endmodule

// File: rtl/disp_port_pick.sv
`timescale 1ns/1ps
module disp_port_pick #(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0]            cand_i,
  input  logic [N_ENT-1:0][N_ENT-1:0] beats_i,
  output logic [N_ENT-1:0]            win_o,
  output logic                        vld_o,
  output logic [IDX_W-1:0]            idx_o
);
  always_comb begin
    logic ok;
    win_o = '0;
    idx_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      ok = cand_i[i];
      for (int j = 0; j < N_ENT; j++)
        if (j != i && cand_i[j] && !beats_i[i][j]) ok = 1'b0;
      win_o[i] = ok;
    end
    for (int i = 0; i < N_ENT; i++)
      if (win_o[i]) idx_o = idx_o | IDX_W'(i);
    vld_o = |win_o;
  end
endmodule

// File: rtl/disp_div_track.sv
`timescale 1ns/1ps
module disp_div_track #(
  parameter int DIV_GAP = 4,
  localparam int CNT_W = (DIV_GAP > 2) ? $clog2(DIV_GAP) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_go_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (div_go_i)    cnt_q <= CNT_W'(DIV_GAP - 1);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  if (DIV_GAP > 1) begin : g_chk
    AST_DIV_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_go_i |=> !div_go_i); // R7
  end
endmodule

// File: rtl/dispatch_select.sv
`timescale 1ns/1ps
module dispatch_select
  import dispatch_pkg::*;
#(
  parameter int N_ENT   = 16,
  parameter int AGE_W   = 6,
  parameter int DIV_GAP = 4,
  localparam int IDX_W  = $clog2(N_ENT)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [N_ENT-1:0]                   ent_vld_i,
  input  logic [N_ENT-1:0]                   ent_rdy_i,
  input  logic [N_ENT-1:0][AGE_W-1:0]        ent_age_i,
  input  logic [N_ENT-1:0][CLS_W-1:0]        ent_cls_i,
  input  logic [NPORTS-1:0]                  port_busy_i,
  output logic [NPORTS-1:0]                  grant_vld_o,
  output logic [NPORTS-1:0][IDX_W-1:0]       grant_idx_o
);
  logic [N_ENT-1:0][N_ENT-1:0] beats;
  logic [N_ENT-1:0]            cand_col [NPORTS];
  logic [N_ENT-1:0]            taken    [NPORTS+1];
  logic [N_ENT-1:0]            win      [NPORTS];
  logic                        sel_vld  [NPORTS];
  logic [IDX_W-1:0]            sel_idx  [NPORTS];
  logic                        div_busy, div_go;

  disp_age_matrix #(.N_ENT(N_ENT), .AGE_W(AGE_W)) i_age (
    .age_i  (ent_age_i),
    .beats_o(beats)
  );

  always_comb begin
    for (int p = 0; p < NPORTS; p++)
      for (int e = 0; e < NPORTS*0 + N_ENT; e++)
        cand_col[p][e] = ent_vld_i[e] && ent_rdy_i[e] && !port_busy_i[p]
                      && port_ok(ent_cls_i[e], p)
                      && !(p == 0 && ent_cls_i[e] == CLS_DIV && div_busy);
  end

  assign taken[0] = '0;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    disp_port_pick #(.N_ENT(N_ENT)) i_pick (
      .cand_i (cand_col[p] & ~taken[p]),
      .beats_i(beats),
      .win_o  (win[p]),
      .vld_o  (sel_vld[p]),
      .idx_o  (sel_idx[p])
    );
    assign taken[p+1] = taken[p] | win[p];

    AST_BUSY_PORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_vld[p] |-> !port_busy_i[p]); // R6
    AST_PORT_CLASS_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_vld[p] |-> port_ok(ent_cls_i[sel_idx[p]], p)); // R3
    AST_READY_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_vld[p] |-> (ent_vld_i[sel_idx[p]] && ent_rdy_i[sel_idx[p]])); // R2
    AST_GRANT_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_vld[p] |=> (grant_vld_o[p] && grant_idx_o[p] == $past(sel_idx[p]))); // R8
    for (genvar q = p + 1; q < NPORTS; q++) begin : g_pair
      AST_UNIQUE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(grant_vld_o[p] && grant_vld_o[q] && grant_idx_o[p] == grant_idx_o[q])); // R5
    end
  end

  assign div_go = sel_vld[0] && (ent_cls_i[sel_idx[0]] == CLS_DIV);

  disp_div_track #(.DIV_GAP(DIV_GAP)) i_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_go_i(div_go),
    .busy_o  (div_busy)
  );

  AST_DIV_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_busy |-> !div_go); // R7

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_vld_o <= '0;
      grant_idx_o <= '0;
    end else begin
      for (int p = 0; p < NPORTS; p++) begin
        grant_vld_o[p] <= sel_vld[p];
        grant_idx_o[p] <= sel_vld[p] ? sel_idx[p] : '0;
      end
    end
  end
endmodule

// File: tb/test_dispatch_select.sv
`timescale 1ns/1ps
module test_dispatch_select;
  localparam int N = 16;
  localparam int AW = 6;
  localparam int IW = 4;
  localparam logic [3:0] C_ALU = 4'd0, C_SHIFT = 4'd1, C_BR = 4'd2, C_LEA = 4'd3,
    C_IMUL = 4'd4, C_FMA = 4'd6, C_FMUL = 4'd7, C_DIV = 4'd8, C_FADD = 4'd9,
    C_SHUF = 4'd11, C_LOAD = 4'd13, C_STA = 4'd14, C_STD = 4'd15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] ent_vld, ent_rdy;
  logic [N-1:0][AW-1:0] ent_age;
  logic [N-1:0][3:0] ent_cls;
  logic [7:0] port_busy;
  logic [7:0] grant_vld;
  logic [7:0][IW-1:0] grant_idx;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dispatch_select #(.N_ENT(N), .AGE_W(AW), .DIV_GAP(4)) i_dispatch_select (
    .clk_i(clk), .rst_ni(rst_n), .ent_vld_i(ent_vld), .ent_rdy_i(ent_rdy),
    .ent_age_i(ent_age), .ent_cls_i(ent_cls), .port_busy_i(port_busy),
    .grant_vld_o(grant_vld), .grant_idx_o(grant_idx));

  task automatic clear_all();
    ent_vld = '0; ent_rdy = '0; ent_age = '0; ent_cls = '0; port_busy = '0;
  endtask

  task automatic set_ent(int i, logic [3:0] c, int age, logic rdy = 1'b1);
    ent_vld[i] = 1'b1; ent_rdy[i] = rdy; ent_age[i] = AW'(age); ent_cls[i] = c;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk_port(string req, int p, logic ev, int ei);
    n_chk++;
    if (grant_vld[p] !== ev || (ev && grant_idx[p] !== IW'(ei))) begin
      n_fail++;
      $display("FAIL %s port %0d: got vld=%0b idx=%0d, expected vld=%0b idx=%0d",
               req, p, grant_vld[p], grant_idx[p], ev, ei);
    end
  endtask

  task automatic idle();
    clear_all(); step();
  endtask

  task automatic t_reset();
    clear_all(); rst_n = 1'b0;
    set_ent(0, C_ALU, 0);
    repeat (2) @(negedge clk);
    for (int p = 0; p < 8; p++) chk_port("R1 in reset", p, 1'b0, 0);
    clear_all(); rst_n = 1'b1; step();
    for (int p = 0; p < 8; p++) chk_port("R1 after reset", p, 1'b0, 0);
  endtask

  task automatic t_age_order();
    idle();
    set_ent(3, C_ALU, 0); set_ent(1, C_ALU, 1); set_ent(7, C_ALU, 2);
    set_ent(2, C_ALU, 3); set_ent(0, C_ALU, 4);
    #1 chk_port("R8 not before edge", 0, 1'b0, 0);
    step();
    chk_port("R4 oldest port0", 0, 1'b1, 3);
    chk_port("R5 fallback port1", 1, 1'b1, 1);
    chk_port("R5 fallback port5", 5, 1'b1, 7);
    chk_port("R5 fallback port6", 6, 1'b1, 2);
    chk_port("R3 alu not on port2", 2, 1'b0, 0);
    clear_all(); step();
    chk_port("R8 grant drops", 0, 1'b0, 0);
  endtask

  task automatic t_not_ready();
    idle();
    set_ent(5, C_ALU, 0, 1'b0);
    set_ent(6, C_ALU, 1); ent_vld[6] = 1'b0;
    set_ent(4, C_ALU, 2);
    step();
    chk_port("R2 ready only", 0, 1'b1, 4);
    chk_port("R2 no second", 1, 1'b0, 0);
  endtask

  task automatic t_wrap_tie();
    idle();
    set_ent(1, C_SHIFT, 1); set_ent(0, C_SHIFT, 62);
    set_ent(9, C_FADD, 10); set_ent(4, C_FADD, 10);
    step();
    chk_port("R4 wrap older", 0, 1'b1, 0);
    chk_port("R4 wrap younger", 6, 1'b1, 1);
    chk_port("R4 tie low index", 1, 1'b1, 4);
  endtask

  task automatic t_busy();
    idle();
    port_busy[0] = 1'b1;
    set_ent(2, C_FMA, 5); set_ent(8, C_BR, 3);
    step();
    chk_port("R6 busy port idle", 0, 1'b0, 0);
    chk_port("R6 fma to port1", 1, 1'b1, 2);
    chk_port("R6 branch to port6", 6, 1'b1, 8);
  endtask

  task automatic t_single_grant();
    idle();
    set_ent(0, C_LEA, 0); set_ent(1, C_IMUL, 1);
    step();
    chk_port("R5 lea on port1", 1, 1'b1, 0);
    chk_port("R5 lea not twice", 5, 1'b0, 0);
  endtask

  task automatic t_full();
    idle();
    set_ent(0, C_BR, 0); set_ent(1, C_BR, 1); set_ent(2, C_FADD, 2);
    set_ent(3, C_SHUF, 3); set_ent(4, C_LOAD, 4); set_ent(5, C_LOAD, 5);
    set_ent(6, C_STD, 6); set_ent(7, C_STA, 7);
    step();
    chk_port("R9 branch a", 0, 1'b1, 0);
    chk_port("R9 fadd", 1, 1'b1, 2);
    chk_port("R10 load a", 2, 1'b1, 4);
    chk_port("R10 load b", 3, 1'b1, 5);
    chk_port("R10 store data", 4, 1'b1, 6);
    chk_port("R9 shuffle", 5, 1'b1, 3);
    chk_port("R9 branch b", 6, 1'b1, 1);
    chk_port("R10 store addr", 7, 1'b1, 7);
  endtask

  task automatic t_divider();
    repeat (4) idle();
    set_ent(0, C_DIV, 0);
    step();
    chk_port("R7 first divide", 0, 1'b1, 0);
    clear_all(); set_ent(1, C_DIV, 1); set_ent(2, C_FMUL, 2);
    step();
    chk_port("R7 fmul while blocked", 0, 1'b1, 2);
    clear_all(); set_ent(1, C_DIV, 1);
    step();
    chk_port("R7 divide held gap2", 0, 1'b0, 0);
    step();
    chk_port("R7 divide held gap3", 0, 1'b0, 0);
    step();
    chk_port("R7 divide after gap", 0, 1'b1, 1);
    clear_all(); step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_all();
    t_reset();
    t_age_order();
    t_not_ready();
    t_wrap_tie();
    t_busy();
    t_single_grant();
    t_full();
    t_divider();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule